// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block sits beside a small 8-bit processor core and decides when the core must abandon its normal instruction stream and call an interrupt handler. Ten request sources feed it: two timer overflows, one serial channel and seven external event lines. Each source latches a sticky request flag. The flags are snapshotted on machine-cycle strobes. The snapshot is then masked by per-source enables and a global enable. An arbiter picks one winner across two priority levels.

At each instruction boundary reported by the core, the controller may issue a one-cycle vector request that carries the handler address. It then clears the winning flag and marks that priority level as in service. A return-from-interrupt reported at a boundary closes the innermost level. Acknowledgement is held back at any boundary that ends a return-from-interrupt instruction, and at any boundary that ends an instruction that wrote a configuration register. This gives software one instruction of grace after changing masks or priorities.

Source index n runs 0..9 in this order: external 0, timer 0, external 1, timer 1, serial 0, external 2 to external 6. This index is also the polling order.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all four configuration registers read 0, `vec_req` is 0 and `svc_level` is 2'b00.
- R2: Register map, with writes when `wr_en`=1 and combinational reads at `addr`:
  - addr 0 is the first enable register: bits 0..4 enable sources 0..4, bit 7 is the global enable, bit 6 is storage only and bit 5 reads 0.
  - addr 1 is the second enable register: bits 1..5 enable sources 5..9; bits 0, 6 and 7 read 0.
  - addr 2 holds the priority bits for sources 0..4 in bits 0..4.
  - addr 3 holds the priority bits for sources 5..9 in bits 0..4.
  - In addr 2 and 3, bits 5..7 read 0, and a priority bit of 1 means high level.
- R3: A pulse on `req_in[n]` latches that source's flag even while the source is disabled. It is acknowledged later, once enabled.
- R4: With the global enable bit at 0, no vector request is issued, whatever the other enables are.
- R5: An acknowledgement is issued only at a boundary (`instr_end`=1). `vec_req` pulses on the next clock with `vec_addr` = 0x0003 + 8·n. The flag of source n is cleared, so one event yields one acknowledgement.
- R6: A request is not acknowledged while a level equal to or above its own is in service.
- R7: A high-level request preempts a running low-level handler. `svc_level` bit 0 marks low in service and bit 1 marks high in service.
- R8: No acknowledgement is given at a boundary where `op_reti`=1. None is given at a boundary that ends an instruction during which `wr_en` was asserted. The request is taken at the next plain boundary.
- R9: A boundary with `op_reti`=1 clears the highest set bit of `svc_level`.
- R10: Among eligible requests, a high-level one wins over any low-level one. Within a level, the lowest source index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration register write strobe |
| addr | input | 2 | Configuration register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| req_in | input | 10 | Per-source request pulses, index = polling order |
| mcyc | input | 1 | Machine-cycle strobe; snapshots the flags |
| instr_end | input | 1 | Current instruction completes this cycle |
| op_reti | input | 1 | The completing instruction is a return-from-interrupt |
| vec_req | output | 1 | One-cycle request to force a call |
| vec_addr | output | 16 | Handler address for `vec_req` |
| svc_level | output | 2 | In-service levels, bit 1 high, bit 0 low |

## Verification
A corrupted flag or snapshot shows up as a missing vector request or an extra one, one clock after the next boundary at which the source would be eligible. A wrong in-service state changes which of two queued requests is taken, or lets an equal-level request through. Both are visible on `svc_level` and `vec_addr` at the very next boundary. The bench therefore keeps an ordered queue of expected handler addresses. Any vector request that is out of order or not expected is reported as soon as it appears.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC     = 10;
  localparam int IW       = $clog2(NSRC);
  localparam int AW       = 16;
  localparam int VEC_BASE = 3;
  localparam int VEC_STEP = 8;

  typedef logic [NSRC-1:0] src_vec_t;

  // handler address of source idx
  function automatic logic [AW-1:0] vec_of(input logic [IW-1:0] idx);
    return AW'(VEC_BASE + VEC_STEP * int'(idx));
  endfunction

  // lowest set index of m (polling order)
  function automatic logic [IW-1:0] lowest_idx(input src_vec_t m);
    logic [IW-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (m[i]) r = IW'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irqc_cfg.sv
module irqc_cfg
  import irqc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output src_vec_t   en_src,
  output src_vec_t   prio_src,
  output logic       glob_en
);
  localparam logic [7:0] MASK_ENA = 8'hDF;
  localparam logic [7:0] MASK_ENB = 8'h3E;
  localparam logic [7:0] MASK_PR  = 8'h1F;

  logic [7:0] en_a, en_b, pr_a, pr_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_a <= '0;
      en_b <= '0;
      pr_a <= '0;
      pr_b <= '0;
    end else if (wr_en) begin
      case (addr)
        2'd0: en_a <= wdata & MASK_ENA;
        2'd1: en_b <= wdata & MASK_ENB;
        2'd2: pr_a <= wdata & MASK_PR;
        default: pr_b <= wdata & MASK_PR;
      endcase
    end
  end

  always_comb begin
    case (addr)
      2'd0: rdata = en_a;
      2'd1: rdata = en_b;
      2'd2: rdata = pr_a;
      default: rdata = pr_b;
    endcase
  end

  assign en_src   = {en_b[5:1], en_a[4:0]};
  assign prio_src = {pr_b[4:0], pr_a[4:0]};
  assign glob_en  = en_a[7];
endmodule

// File: rtl/irqc_flags.sv
module irqc_flags
  import irqc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t req_in,
  input  logic     mcyc,
  input  src_vec_t clr,
  output src_vec_t flags,
  output src_vec_t samp
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n)         flags[i] <= 1'b0;
      else if (req_in[i]) flags[i] <= 1'b1;
      else if (clr[i])    flags[i] <= 1'b0;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)      samp[i] <= 1'b0;
      else if (clr[i]) samp[i] <= 1'b0;
      else if (mcyc)   samp[i] <= flags[i];
    end
  end
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
  import irqc_pkg::*;
(
  input  src_vec_t       samp,
  input  src_vec_t       en_src,
  input  src_vec_t       prio_src,
  input  logic           glob_en,
  input  logic [1:0]     svc,
  output logic           hit,
  output logic [IW-1:0]  idx,
  output logic           lvl
);
  src_vec_t cand, hi, lo;

  assign cand = samp & en_src & {NSRC{glob_en}};
  assign hi   = cand & prio_src;
  assign lo   = cand & ~prio_src;

  always_comb begin
    hit = 1'b0;
    idx = '0;
    lvl = 1'b0;
    if (hi != '0 && !svc[1]) begin
      hit = 1'b1;
      idx = lowest_idx(hi);
      lvl = 1'b1;
    end else if (lo != '0 && svc == 2'b00) begin
      hit = 1'b1;
      idx = lowest_idx(lo);
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic [9:0]    req_in,
  input  logic          mcyc,
  input  logic          instr_end,
  input  logic          op_reti,
  output logic          vec_req,
  output logic [15:0]   vec_addr,
  output logic [1:0]    svc_level
);
  src_vec_t      en_src, prio_src, flags, samp, clr;
  logic          glob_en, hit, lvl, cfg_seen, defer, take;
  logic [IW-1:0] idx;

  irqc_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .en_src(en_src), .prio_src(prio_src), .glob_en(glob_en)
  );

  irqc_flags u_flags (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .mcyc(mcyc),
    .clr(clr), .flags(flags), .samp(samp)
  );

  irqc_arb u_arb (
    .samp(samp), .en_src(en_src), .prio_src(prio_src), .glob_en(glob_en),
    .svc(svc_level), .hit(hit), .idx(idx), .lvl(lvl)
  );

  // remembers a config write inside the running instruction
  always_ff @(posedge clk) begin
    if (!rst_n)         cfg_seen <= 1'b0;
    else if (instr_end) cfg_seen <= 1'b0;
    else if (wr_en)     cfg_seen <= 1'b1;
  end

  assign defer = op_reti | cfg_seen | wr_en;
  assign take  = instr_end & hit & ~defer;
  assign clr   = take ? (src_vec_t'(1) << idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      svc_level <= 2'b00;
    end else if (instr_end && op_reti) begin
      if (svc_level[1]) svc_level[1] <= 1'b0;
      else              svc_level[0] <= 1'b0;
    end else if (take) begin
      svc_level[lvl] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_req  <= 1'b0;
      vec_addr <= '0;
    end else begin
      vec_req <= take;
      if (take) vec_addr <= vec_of(idx);
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       instr_end,
  input logic       op_reti,
  input logic       glob_en,
  input logic       vec_req,
  input logic [1:0] svc_level
);
  p_ack_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> $past(instr_end));

  p_reti_defers_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_end && op_reti) |=> !vec_req);

  p_write_defers_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_end && wr_en) |=> !vec_req);

  p_global_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> $past(glob_en));

  p_level_grows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> ($countones(svc_level) > $countones($past(svc_level))));

  p_top_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> !$past(svc_level[1]));

  p_reti_shrinks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_end && op_reti && svc_level != 2'b00) |=>
      ($countones(svc_level) < $countones($past(svc_level))));
endmodule

bind irq_prio_ctrl irqc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .instr_end(instr_end),
  .op_reti(op_reti), .glob_en(glob_en), .vec_req(vec_req),
  .svc_level(svc_level)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [9:0]  req_in = '0;
  logic        mcyc = 1'b1;
  logic        instr_end = 1'b0;
  logic        op_reti = 1'b0;
  logic        vec_req;
  logic [15:0] vec_addr;
  logic [1:0]  svc_level;

  int total = 0;
  int bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .req_in(req_in), .mcyc(mcyc), .instr_end(instr_end),
    .op_reti(op_reti), .vec_req(vec_req), .vec_addr(vec_addr),
    .svc_level(svc_level)
  );

  function automatic logic [15:0] addr_for(int n);
    return 16'(3 + n * 8);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_vec(input int n, input string req);
    exp_q.push_back(addr_for(n));
    tag_q.push_back(req);
  endtask

  // monitor: every vector request must match the head of the queue
  always @(negedge clk) begin
    if (rst_n && vec_req) begin
      if (exp_q.size() == 0) begin
        total++;
        bad++;
        $display("FAIL unexpected vector actual=%h expected=none", vec_addr);
      end else begin
        string t;
        logic [15:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, vec_addr, e);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input logic [1:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    addr = a;
    #1;
    check(req, 16'(rdata), 16'(e));
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    req_in[n] = 1'b1;
    @(negedge clk);
    req_in = '0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic boundary(input logic reti);
    @(negedge clk);
    instr_end = 1'b1; op_reti = reti;
    @(negedge clk);
    instr_end = 1'b0; op_reti = 1'b0;
  endtask

  task automatic svc_check(input logic [1:0] e, input string req);
    check(req, 16'(svc_level), 16'(e));
  endtask

  task automatic finish_up;
    check("queue drained", 16'(exp_q.size()), 16'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_check(2'd0, 8'h00, "R1 reg0");
    rd_check(2'd3, 8'h00, "R1 reg3");
    check("R1 vec_req", 16'(vec_req), 16'd0);
    svc_check(2'b00, "R1 svc");

    // R2 map and unused bits
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'hFF);
    rd_check(2'd0, 8'hDF, "R2 reg0");
    rd_check(2'd1, 8'h3E, "R2 reg1");
    rd_check(2'd2, 8'h1F, "R2 reg2");
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);
    boundary(1'b0);

    // R3 masked source still latches
    pulse(0);
    boundary(1'b0);
    boundary(1'b0);
    wr(2'd0, 8'h81);
    boundary(1'b0);        // R8 write in this instruction defers
    expect_vec(0, "R3 latched while masked");
    boundary(1'b0);
    svc_check(2'b01, "R5 low level in service");
    boundary(1'b1);
    svc_check(2'b00, "R9 reti clears low");

    // R10 lowest index within level, R6 equal level blocks
    wr(2'd0, 8'h9F);
    boundary(1'b0);
    pulse(3);
    pulse(1);
    expect_vec(1, "R10 lowest index first");
    boundary(1'b0);
    boundary(1'b0);        // src3 blocked by equal level (R6)
    svc_check(2'b01, "R6 svc still low");
    boundary(1'b1);
    expect_vec(3, "R5 second request");
    boundary(1'b0);
    boundary(1'b1);

    // R7 preemption
    wr(2'd1, 8'h3E);
    wr(2'd3, 8'h10);       // source 9 high
    boundary(1'b0);
    pulse(2);
    expect_vec(2, "R7 low handler");
    boundary(1'b0);
    pulse(9);
    expect_vec(9, "R7 high preempts");
    boundary(1'b0);
    svc_check(2'b11, "R7 both levels");
    pulse(0);
    boundary(1'b0);        // blocked by high
    boundary(1'b1);
    svc_check(2'b01, "R9 reti clears high first");
    boundary(1'b0);        // blocked by low
    boundary(1'b1);
    svc_check(2'b00, "R9 reti clears low");
    expect_vec(0, "R6 released after reti");
    boundary(1'b0);
    boundary(1'b1);

    // R10 high beats lower index, R8 stray reti defers
    pulse(0);
    pulse(9);
    boundary(1'b1);        // R8 deferred
    svc_check(2'b00, "R8 no ack on reti boundary");
    expect_vec(9, "R10 high level first");
    boundary(1'b0);
    boundary(1'b1);
    expect_vec(0, "R10 low after");
    boundary(1'b0);
    boundary(1'b1);

    // R4 global enable
    wr(2'd0, 8'h1F);
    boundary(1'b0);
    pulse(1);
    boundary(1'b0);
    boundary(1'b0);
    svc_check(2'b00, "R4 global off");
    wr(2'd0, 8'h9F);
    boundary(1'b0);
    expect_vec(1, "R4 after global on");
    boundary(1'b0);
    boundary(1'b1);
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule